// File: doc/BRIEF.md
# Multi-Cycle Integer Divider with Condition Codes

This block performs the integer divide operations of a processor pipeline. It has three operand forms: a 32-bit dividend over a 16-bit divisor, a 32-bit dividend over a 32-bit divisor, and a 64-bit dividend over a 32-bit divisor. Each form comes in a signed and an unsigned variant. One quotient bit is produced per clock by a restoring shift-subtract loop that works on magnitudes. The signs of the quotient and remainder are fixed up after the last step.

A request is accepted when `start` is high while the block is idle. The block then returns its results as a short sequence of register write-back beats on a single write port. At the end it raises `done` for one cycle, with the N, Z, V and C condition flags valid. A zero divisor writes nothing and raises a divide-by-zero trap request together with `done`. A quotient that does not fit the result width also writes nothing, and it sets the overflow flag. The register file and the trap handling live outside the block.

Top module: `int_divider`

## Requirements
- R1: A zero effective divisor makes `done` and `divZeroTrap` high together in the cycle after the start, with no write-back beat and all four flags left unchanged. In the word form, only divisor bits 15:0 count toward the effective divisor.
- R2: After every completed divide, flagC is 0.
- R3: Overflow occurs when the true quotient does not fit the result width (16 bits in the word form, 32 bits otherwise). An unsigned quotient overflows above its maximum value. A signed quotient overflows when it differs from the sign extension of its low bits. On overflow there is no write-back beat, V=1, Z=0, C=0 and N keeps its previous value.
- R4: The word form is selected by opSize=2'b00. Without overflow it produces exactly one write-back beat to quoIdx, with data {remainder[15:0], quotient[15:0]}.
- R5: In the word form without overflow, N is quotient bit 15, Z is 1 exactly when quotient[15:0] is zero, and V is 0.
- R6: The quad form is selected by opSize[1]=1. Its 64-bit dividend is {dividendHi, dividendLo}, and it returns a 32-bit quotient and a 32-bit remainder.
- R7: In the long and quad forms without overflow there are two write-back beats in consecutive cycles: the remainder to remIdx first, then the quotient to quoIdx. When the two indices are equal, the quotient is therefore the value that remains.
- R8: Signed division truncates toward zero. The remainder takes the sign of the dividend, and the quotient is negative exactly when the operand signs differ.
- R9: The long form is selected by opSize=2'b01 and uses only dividendLo as its dividend. Without overflow, N is quotient bit 31 and Z is 1 exactly when quotient[31:0] is zero. The signed divide of -2^31 by -1 overflows.
- R10: `busy` is high from the cycle after an accepted start until `done`, and a start seen while busy is ignored. `done` lasts one cycle and comes no later than 36 cycles after the start in the word and long forms, and no later than 68 cycles in the quad form.
- R11: After reset, busy, done, divZeroTrap, wbValid and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a divide; accepted only while idle |
| opSize | input | 2 | 00 word, 01 long, 1x quad |
| opSigned | input | 1 | 1 for signed division |
| dividendHi | input | 32 | Upper dividend word (quad form only) |
| dividendLo | input | 32 | Lower dividend word, or the whole dividend |
| divisor | input | 32 | Divisor; bits 15:0 only in the word form |
| quoIdx | input | 3 | Destination register index for the quotient |
| remIdx | input | 3 | Destination register index for the remainder |
| busy | output | 1 | Divide in progress |
| done | output | 1 | One-cycle completion pulse; flags are valid |
| divZeroTrap | output | 1 | Divide-by-zero trap request, high with done |
| wbValid | output | 1 | Write-back beat valid |
| wbIdx | output | 3 | Write-back register index |
| wbData | output | 32 | Write-back data |
| flagN | output | 1 | Negative flag |
| flagZ | output | 1 | Zero flag |
| flagV | output | 1 | Overflow flag |
| flagC | output | 1 | Carry flag |

## Verification
A wrong step counter or a wrong final state shows at the ports as a `done` that arrives early or late. The write-back data would then be truncated to fewer quotient bits, so a single divide with a large dividend exposes it as soon as `done` appears. A wrong latched sign or mode bit shows in the first write-back beat, as a flipped sign or a wrong packing. A stale flag register shows in the N value observed after the next overflowing divide. Random operands across all six forms, mixed with the directed boundaries (zero divisor, -2^31 over -1, equal indices, a start while busy), reach each of these within a few hundred cycles.

// File: rtl/intdiv_pkg.sv
package intdiv_pkg;
  typedef struct packed {
    logic load;
    logic step;
    logic flagLoad;
    logic wrRem;
    logic wrQuo;
  } divStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE, S_CALC, S_FIN, S_WRR, S_WRQ, S_DONE, S_TRAP
  } divState_e;
endpackage

// File: rtl/intdiv_ctrl.sv
module intdiv_ctrl
  import intdiv_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [1:0] opSize,
  input  logic       divZero,
  input  logic       ovfDet,
  output divStrobe_t strb,
  output logic       busy,
  output logic       done,
  output logic       trap
);
  localparam int DW2   = 2 * DW;
  localparam int CNT_W = $clog2(DW2);

  divState_e state;
  logic [CNT_W-1:0] stepCnt;
  logic isQuad, isWord;
  logic [CNT_W-1:0] lastStep;

  assign lastStep = isQuad ? CNT_W'(DW2 - 1) : CNT_W'(DW - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepCnt <= '0;
      isQuad  <= 1'b0;
      isWord  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          isQuad  <= opSize[1];
          isWord  <= (opSize == 2'b00);
          stepCnt <= '0;
          state   <= divZero ? S_TRAP : S_CALC;
        end
        S_CALC: begin
          stepCnt <= stepCnt + 1'b1;
          if (stepCnt == lastStep) state <= S_FIN;
        end
        S_FIN: begin
          if (ovfDet)      state <= S_DONE;
          else if (isWord) state <= S_WRQ;
          else             state <= S_WRR;
        end
        S_WRR:   state <= S_WRQ;
        S_WRQ:   state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.load     = (state == S_IDLE) && start && !divZero;
    strb.step     = (state == S_CALC);
    strb.flagLoad = (state == S_FIN);
    strb.wrRem    = (state == S_WRR);
    strb.wrQuo    = (state == S_WRQ);
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_DONE) || (state == S_TRAP);
  assign trap = (state == S_TRAP);
endmodule

// File: rtl/intdiv_dp.sv
module intdiv_dp
  import intdiv_pkg::*;
#(
  parameter int DW    = 32,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  divStrobe_t       strb,
  input  logic [1:0]       opSize,
  input  logic             opSigned,
  input  logic [DW-1:0]    dividendHi,
  input  logic [DW-1:0]    dividendLo,
  input  logic [DW-1:0]    divisor,
  input  logic [IDX_W-1:0] quoIdx,
  input  logic [IDX_W-1:0] remIdx,
  output logic             divZero,
  output logic             ovfDet,
  output logic             wbValid,
  output logic [IDX_W-1:0] wbIdx,
  output logic [DW-1:0]    wbData,
  output logic             flagN,
  output logic             flagZ,
  output logic             flagV,
  output logic             flagC
);
  localparam int DW2 = 2 * DW;
  localparam int HW  = DW / 2;

  logic inWord, inQuad;
  logic [DW-1:0]  dvsEff, dvsAbs, dvdLoAbs;
  logic [DW2-1:0] dvdQuadAbs;
  logic inDvdNeg, inDvsNeg;

  assign inWord   = (opSize == 2'b00);
  assign inQuad   = opSize[1];
  assign dvsEff   = inWord ? {{HW{opSigned & divisor[HW-1]}}, divisor[HW-1:0]} : divisor;
  assign divZero  = (dvsEff == '0);
  assign inDvsNeg = opSigned & dvsEff[DW-1];
  assign inDvdNeg = opSigned & (inQuad ? dividendHi[DW-1] : dividendLo[DW-1]);
  assign dvsAbs   = inDvsNeg ? -dvsEff : dvsEff;
  assign dvdLoAbs = inDvdNeg ? -dividendLo : dividendLo;
  assign dvdQuadAbs = inDvdNeg ? -{dividendHi, dividendLo} : {dividendHi, dividendLo};

  logic sgnR, wordR, dvdNegR, dvsNegR;
  logic [DW-1:0]    dvsMag, remMag;
  logic [DW2-1:0]   numQ;
  logic [IDX_W-1:0] qIdxR, rIdxR;
  logic [DW:0]      trial;

  assign trial = {remMag, numQ[DW2-1]} - {1'b0, dvsMag};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sgnR <= 1'b0; wordR <= 1'b0; dvdNegR <= 1'b0; dvsNegR <= 1'b0;
      dvsMag <= '0; remMag <= '0; numQ <= '0; qIdxR <= '0; rIdxR <= '0;
    end else if (strb.load) begin
      sgnR    <= opSigned;
      wordR   <= inWord;
      dvdNegR <= inDvdNeg;
      dvsNegR <= inDvsNeg;
      dvsMag  <= dvsAbs;
      remMag  <= '0;
      numQ    <= inQuad ? dvdQuadAbs : {dvdLoAbs, {DW{1'b0}}};
      qIdxR   <= quoIdx;
      rIdxR   <= remIdx;
    end else if (strb.step) begin
      if (!trial[DW]) remMag <= trial[DW-1:0];
      else            remMag <= {remMag[DW-2:0], numQ[DW2-1]};
      numQ <= {numQ[DW2-2:0], ~trial[DW]};
    end
  end

  logic [DW2-1:0] quoSgn;
  logic [DW-1:0]  remSgn;
  logic resN, resZ;

  assign quoSgn = (dvdNegR ^ dvsNegR) ? -numQ : numQ;
  assign remSgn = dvdNegR ? -remMag : remMag;

  always_comb begin
    if (wordR)
      ovfDet = sgnR ? (quoSgn != {{(DW2-HW){quoSgn[HW-1]}}, quoSgn[HW-1:0]})
                    : (|quoSgn[DW2-1:HW]);
    else
      ovfDet = sgnR ? (quoSgn != {{DW{quoSgn[DW-1]}}, quoSgn[DW-1:0]})
                    : (|quoSgn[DW2-1:DW]);
  end

  assign resN = wordR ? quoSgn[HW-1] : quoSgn[DW-1];
  assign resZ = wordR ? (quoSgn[HW-1:0] == '0) : (quoSgn[DW-1:0] == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagN <= 1'b0; flagZ <= 1'b0; flagV <= 1'b0; flagC <= 1'b0;
    end else if (strb.flagLoad) begin
      flagC <= 1'b0;
      if (ovfDet) begin
        flagV <= 1'b1;
        flagZ <= 1'b0;
      end else begin
        flagV <= 1'b0;
        flagN <= resN;
        flagZ <= resZ;
      end
    end
  end

  assign wbValid = strb.wrRem | strb.wrQuo;
  assign wbIdx   = strb.wrRem ? rIdxR : qIdxR;
  always_comb begin
    if (strb.wrRem)  wbData = remSgn;
    else if (wordR)  wbData = {remSgn[HW-1:0], quoSgn[HW-1:0]};
    else             wbData = quoSgn[DW-1:0];
  end
endmodule

// File: rtl/int_divider.sv
module int_divider
  import intdiv_pkg::*;
#(
  parameter int DW    = 32,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       opSize,
  input  logic             opSigned,
  input  logic [DW-1:0]    dividendHi,
  input  logic [DW-1:0]    dividendLo,
  input  logic [DW-1:0]    divisor,
  input  logic [IDX_W-1:0] quoIdx,
  input  logic [IDX_W-1:0] remIdx,
  output logic             busy,
  output logic             done,
  output logic             divZeroTrap,
  output logic             wbValid,
  output logic [IDX_W-1:0] wbIdx,
  output logic [DW-1:0]    wbData,
  output logic             flagN,
  output logic             flagZ,
  output logic             flagV,
  output logic             flagC
);
  divStrobe_t strb;
  logic divZero, ovfDet;

  intdiv_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opSize(opSize),
    .divZero(divZero), .ovfDet(ovfDet), .strb(strb),
    .busy(busy), .done(done), .trap(divZeroTrap)
  );

  intdiv_dp #(.DW(DW), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .opSize(opSize), .opSigned(opSigned),
    .dividendHi(dividendHi), .dividendLo(dividendLo), .divisor(divisor),
    .quoIdx(quoIdx), .remIdx(remIdx), .divZero(divZero), .ovfDet(ovfDet),
    .wbValid(wbValid), .wbIdx(wbIdx), .wbData(wbData),
    .flagN(flagN), .flagZ(flagZ), .flagV(flagV), .flagC(flagC)
  );
endmodule

// File: rtl/int_divider_chk.sv
module int_divider_chk (
  input logic clk,
  input logic rstN,
  input logic start,
  input logic busy,
  input logic done,
  input logic divZeroTrap,
  input logic wbValid,
  input logic flagV,
  input logic flagZ,
  input logic flagC
);
  AST_TRAP_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    divZeroTrap |-> done); // R1
  AST_TRAP_NO_WB: assert property (@(posedge clk) disable iff (!rstN)
    divZeroTrap |-> !wbValid); // R1
  AST_CARRY_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !flagC); // R2
  AST_OVF_ZERO_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (done && flagV) |-> !flagZ); // R3
  AST_OVF_NO_WB: assert property (@(posedge clk) disable iff (!rstN)
    (done && flagV) |-> !$past(wbValid)); // R3
  AST_WB_IN_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> (busy && !done)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy); // R10
endmodule

bind int_divider int_divider_chk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .divZeroTrap(divZeroTrap), .wbValid(wbValid), .flagV(flagV),
  .flagZ(flagZ), .flagC(flagC)
);

// File: tb/int_divider_tb.sv
`timescale 1ns/1ps
module int_divider_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0, start = 1'b0, opSigned = 1'b0;
  logic [1:0] opSize = 2'b00;
  logic [31:0] dividendHi = '0, dividendLo = '0, divisor = '0;
  logic [2:0] quoIdx = '0, remIdx = '0;
  logic busy, done, divZeroTrap, wbValid, flagN, flagZ, flagV, flagC;
  logic [2:0] wbIdx;
  logic [31:0] wbData;

  int_divider u_dut (.*);

  int nRun = 0, nFail = 0;
  logic expN = 1'b0, expZ = 1'b0, expV = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic runOp(input logic [1:0] sz, input bit sg, input logic [31:0] hi, input logic [31:0] lo,
                       input logic [31:0] dv, input logic [2:0] qi, input logic [2:0] ri, input bit poke,
                       input string tag);
    logic signed [129:0] a, b, q, r;
    bit trapE, ovfE, isW, isQ, gotDone, gotTrap;
    logic [2:0] wIdx[4];
    logic [31:0] wDat[4];
    int nW, lat, latMax;
    logic eN, eZ, eV;
    isW = (sz == 2'b00);
    isQ = sz[1];
    nW = 0; lat = 0; gotDone = 0; gotTrap = 0;
    latMax = isQ ? 68 : 36;
    if (isQ) a = sg ? {{66{hi[31]}}, hi, lo} : {66'b0, hi, lo};
    else     a = sg ? {{98{lo[31]}}, lo} : {98'b0, lo};
    if (isW) b = sg ? {{114{dv[15]}}, dv[15:0]} : {114'b0, dv[15:0]};
    else     b = sg ? {{98{dv[31]}}, dv} : {98'b0, dv};
    trapE = (b == 0);
    q = 0; r = 0; ovfE = 0;
    if (!trapE) begin
      q = a / b;
      r = a % b;
      if (isW) ovfE = sg ? (q < -130'sd32768 || q > 130'sd32767) : (q > 130'sd65535);
      else     ovfE = sg ? (q < -130'sd2147483648 || q > 130'sd2147483647) : (q > 130'sd4294967295);
    end
    @(negedge clk);
    opSize = sz; opSigned = sg; dividendHi = hi; dividendLo = lo; divisor = dv;
    quoIdx = qi; remIdx = ri; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (lat <= 200) begin
      if (wbValid && nW < 4) begin wIdx[nW] = wbIdx; wDat[nW] = wbData; nW++; end
      if (done) begin gotDone = 1; gotTrap = divZeroTrap; break; end
      lat++;
      if (poke && lat == 3) begin
        start = 1'b1; divisor = 32'h0; opSize = 2'b00; dividendLo = 32'hFFFF_FFFF;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk(gotDone && lat <= latMax, "R10 done latency", 64'(lat), 64'(latMax));
    chk(gotTrap == trapE, {tag, " R1 trap"}, 64'(gotTrap), 64'(trapE));
    eN = expN; eZ = expZ; eV = expV;
    if (trapE || ovfE) begin
      chk(nW == 0, trapE ? "R1 no write" : "R3 no write", 64'(nW), 64'd0);
      if (ovfE) begin eV = 1'b1; eZ = 1'b0; end
    end else if (isW) begin
      chk(nW == 1, {tag, " R4 beat count"}, 64'(nW), 64'd1);
      if (nW >= 1)
        chk(wIdx[0] == qi && wDat[0] == {r[15:0], q[15:0]}, {tag, " R4 packed write"},
            {29'b0, wIdx[0], wDat[0]}, {29'b0, qi, r[15:0], q[15:0]});
      eN = q[15]; eZ = (q[15:0] == 16'h0); eV = 1'b0;
    end else begin
      chk(nW == 2, {tag, " R7 beat count"}, 64'(nW), 64'd2);
      if (nW >= 2) begin
        chk(wIdx[0] == ri && wDat[0] == r[31:0], {tag, " R7 remainder first"},
            {29'b0, wIdx[0], wDat[0]}, {29'b0, ri, r[31:0]});
        chk(wIdx[1] == qi && wDat[1] == q[31:0], {tag, isQ ? " R6 quotient" : " R9 quotient"},
            {29'b0, wIdx[1], wDat[1]}, {29'b0, qi, q[31:0]});
      end
      eN = q[31]; eZ = (q[31:0] == 32'h0); eV = 1'b0;
    end
    chk(flagC == 1'b0, "R2 carry", 64'(flagC), 64'd0);
    chk({flagN, flagZ, flagV} == {eN, eZ, eV}, trapE ? "R1 flags kept" : (ovfE ? "R3 flags" : {tag, " R5 flags"}),
        64'({flagN, flagZ, flagV}), 64'({eN, eZ, eV}));
    expN = eN; expZ = eZ; expV = eV;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk({busy, done, divZeroTrap, wbValid, flagN, flagZ, flagV, flagC} == 8'h0, "R11 reset state",
        64'({busy, done, divZeroTrap, wbValid, flagN, flagZ, flagV, flagC}), 64'd0);

    runOp(2'b00, 0, 0, 32'd100, 32'd7, 3'd1, 3'd2, 0, "word unsigned");
    runOp(2'b00, 1, 0, 32'hFFFF_FFF9, 32'd2, 3'd1, 3'd2, 0, "R8 word signed -7/2");
    runOp(2'b00, 1, 0, 32'd7, 32'h0000_FFFE, 3'd3, 3'd2, 0, "R8 word signed 7/-2");
    runOp(2'b00, 1, 0, 32'hFFFF_8000, 32'd1, 3'd0, 3'd2, 0, "R5 word negative result");
    runOp(2'b00, 0, 0, 32'h0001_0000, 32'd1, 3'd1, 3'd2, 0, "R3 word unsigned overflow");
    runOp(2'b00, 1, 0, 32'h0000_8000, 32'd1, 3'd1, 3'd2, 0, "R3 word signed overflow");
    runOp(2'b00, 0, 0, 32'd5, 32'hFFFF_0000, 3'd1, 3'd2, 0, "R1 word divisor low half zero");
    runOp(2'b01, 1, 0, 32'h8000_0000, 32'hFFFF_FFFF, 3'd4, 3'd5, 0, "R9 long min over -1");
    runOp(2'b01, 0, 32'hDEAD_BEEF, 32'd1000, 32'd3, 3'd4, 3'd5, 0, "R9 long ignores high word");
    runOp(2'b01, 1, 0, 32'hFFFF_FF9C, 32'd7, 3'd6, 3'd6, 0, "R7 long same index");
    runOp(2'b10, 0, 32'd5, 32'h1234_5678, 32'd9, 3'd1, 3'd2, 0, "R6 quad unsigned");
    runOp(2'b10, 1, 32'hFFFF_FFFF, 32'h8000_0000, 32'd3, 3'd1, 3'd2, 0, "R8 quad signed");
    runOp(2'b10, 0, 32'd9, 32'd0, 32'd9, 3'd1, 3'd2, 0, "R3 quad overflow");
    runOp(2'b11, 0, 32'd0, 32'd0, 32'd0, 3'd1, 3'd2, 0, "R1 quad zero divisor");
    runOp(2'b01, 0, 0, 32'd77, 32'd10, 3'd1, 3'd2, 1, "R10 start while busy");

    for (int i = 0; i < 150; i++) begin
      logic [1:0] sz;
      logic [31:0] hi, lo, dv;
      bit sg;
      sz = 2'($urandom_range(0, 2));
      sg = 1'($urandom);
      lo = $urandom;
      dv = $urandom;
      if ($urandom_range(0, 3) == 0) dv = dv & 32'h0000_00FF;
      if ($urandom_range(0, 15) == 0) dv = 32'h0;
      hi = $urandom;
      if (sz[1] && $urandom_range(0, 1) == 1) hi = sg ? {{20{hi[31]}}, hi[11:0]} : (hi & 32'h0000_0FFF);
      runOp(sz, sg, hi, lo, dv, 3'($urandom), 3'($urandom), 0, "random");
    end

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule